// File: doc/BRIEF.md
# NOR Flash Command Cycle Sequencer

This block turns one operation request into the series of bus writes that an asynchronous parallel NOR flash expects before it starts that operation. A request names an operation (word program, sector erase, whole-chip erase, software reset, enter fast-program mode, leave fast-program mode). It also carries a target address, a data word, a device-width code and a narrow-mode flag. The block then walks through the unlock and command writes one after another on a plain write-strobe bus, and pulses `done` when the last write has finished.

The unlock addresses depend on the width of the device and, for 16-bit parts, on whether the part runs on a byte-wide bus. While fast-program mode is active, a program request shrinks to a two-write sequence. Every bus write holds address and data steady for `holdClks` clocks on each side of a single-clock strobe. Command bytes appear zero-extended in the low eight bits of `busData`.

Top module: `nor_cmd_seq`

## Requirements
- R1: With fast-program mode off, an operation code of 0 (program) issues four writes in this order: 0xAA to unlock address A, 0x55 to unlock address B, 0xA0 to unlock address A, then `reqData` to `reqAddr`.
- R2: With fast-program mode on, a program request issues exactly two writes: 0xA0 to address 0, then `reqData` to `reqAddr`.
- R3: Code 4 issues 0xAA to A, 0x55 to B and 0x20 to A, and turns fast-program mode on when it completes. Code 5 issues 0x90 then 0x00, both to address 0, and turns the mode off when it completes. Fast-program mode is off after reset.
- R4: Code 1 (sector erase) issues 0xAA to A, 0x55 to B, 0x80 to A, 0xAA to A, 0x55 to B, then 0x30 to `reqAddr`.
- R5: Code 2 (chip erase) issues the same first five writes as R4, then 0x10 to A.
- R6: Device code 0 (8-bit) uses A=0x555 and B=0x2AA. Device code 2 (32-bit) uses A=0x1555 and B=0xAAA.
- R7: Device code 1 (16-bit) uses A=0xAAA. B is 0x555 when `reqNarrow` is 1 and 0x554 when it is 0.
- R8: Code 3 (reset) issues a single write of 0xF0 to address 0, whatever the fast-program mode.
- R9: Each write, with N the `holdClks` value captured at acceptance, occupies N cycles with `busDrive`=1 and `busWe`=0, then one cycle with `busWe`=1, then N more cycles with `busDrive`=1 and `busWe`=0. Address and data stay the same across all 2N+1 cycles. When N=0, a write is a single strobe cycle.
- R10: A request is taken only while `busy` is 0. `busy` rises in the cycle after acceptance and stays high through a one-cycle `done` pulse that directly follows the last cycle of the last write. Requests presented while busy are ignored.
- R11: A device code of 3 or an operation code of 6 or 7 causes a one-cycle `error` pulse (with `busy` high) in the cycle after the request. No bus write is issued and the fast-program mode is left unchanged.
- R12: During and straight after reset, `busy`, `done`, `error`, `busDrive` and `busWe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqOp | input | 3 | Operation code (0 program, 1 sector erase, 2 chip erase, 3 reset, 4 enter fast mode, 5 leave fast mode) |
| reqAddr | input | ADDR_W | Target or sector address |
| reqData | input | DATA_W | Data word to program |
| reqDevType | input | 2 | Device width code (0 8-bit, 1 16-bit, 2 32-bit) |
| reqNarrow | input | 1 | 16-bit device runs on a byte-wide bus |
| holdClks | input | CNT_W | Setup/hold length N in clocks |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | One-cycle rejection pulse |
| busDrive | output | 1 | Address and data valid on the bus |
| busWe | output | 1 | Write strobe |
| busAddr | output | ADDR_W | Bus address |
| busData | output | DATA_W | Bus data |

## Verification
The bench goes after the unlock address B of 16-bit parts in both bus modes. A design that ignored the narrow flag would put 0x554 where 0x555 belongs. It also sequences enter, program, erase, an error and leave, so a fast-mode flag that is set too early, never cleared, or clobbered by a rejected request shows up as a four-write program where two were expected, or the other way round. It runs N=0 back-to-back strobes and longer setup/hold windows, where an off-by-one in the counter shifts every later strobe. Finally, it holds a second request on the inputs while the block is busy, which catches a design that accepts it.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  localparam int STEP_W = 3;

  typedef enum logic [2:0] {
    OP_PROG    = 3'd0,
    OP_SECTOR  = 3'd1,
    OP_CHIP    = 3'd2,
    OP_RESET   = 3'd3,
    OP_FAST_ON = 3'd4,
    OP_FAST_OFF= 3'd5
  } opCode_e;

  typedef enum logic [1:0] {
    SEL_UNL_A,
    SEL_UNL_B,
    SEL_TARGET,
    SEL_ZERO
  } addrSel_e;

  typedef struct packed {
    addrSel_e   addrSel;
    logic       useData;
    logic [7:0] cmd;
    logic       last;
  } stepInfo_t;

  // control -> datapath strobes
  typedef struct packed {
    logic              load;
    logic              finish;
    logic [STEP_W-1:0] step;
  } ctlStrb_t;

  function automatic stepInfo_t mkStep(addrSel_e s, logic d, logic [7:0] c, logic l);
    stepInfo_t r;
    r.addrSel = s;
    r.useData = d;
    r.cmd     = c;
    r.last    = l;
    return r;
  endfunction

  // The five-write prefix shared by both erase kinds.
  function automatic stepInfo_t erasePrefix(logic [STEP_W-1:0] idx);
    case (idx)
      3'd0:    return mkStep(SEL_UNL_A, 1'b0, 8'hAA, 1'b0);
      3'd1:    return mkStep(SEL_UNL_B, 1'b0, 8'h55, 1'b0);
      3'd2:    return mkStep(SEL_UNL_A, 1'b0, 8'h80, 1'b0);
      3'd3:    return mkStep(SEL_UNL_A, 1'b0, 8'hAA, 1'b0);
      default: return mkStep(SEL_UNL_B, 1'b0, 8'h55, 1'b0);
    endcase
  endfunction

  function automatic stepInfo_t stepLookup(logic [2:0] op, logic fast, logic [STEP_W-1:0] idx);
    stepInfo_t r;
    r = mkStep(SEL_ZERO, 1'b0, 8'h00, 1'b1);
    case (op)
      OP_PROG: begin
        if (fast) begin
          if (idx == 3'd0) r = mkStep(SEL_ZERO,   1'b0, 8'hA0, 1'b0);
          else             r = mkStep(SEL_TARGET, 1'b1, 8'h00, 1'b1);
        end else begin
          case (idx)
            3'd0:    r = mkStep(SEL_UNL_A,  1'b0, 8'hAA, 1'b0);
            3'd1:    r = mkStep(SEL_UNL_B,  1'b0, 8'h55, 1'b0);
            3'd2:    r = mkStep(SEL_UNL_A,  1'b0, 8'hA0, 1'b0);
            default: r = mkStep(SEL_TARGET, 1'b1, 8'h00, 1'b1);
          endcase
        end
      end
      OP_SECTOR: r = (idx < 3'd5) ? erasePrefix(idx) : mkStep(SEL_TARGET, 1'b0, 8'h30, 1'b1);
      OP_CHIP:   r = (idx < 3'd5) ? erasePrefix(idx) : mkStep(SEL_UNL_A,  1'b0, 8'h10, 1'b1);
      OP_RESET:  r = mkStep(SEL_ZERO, 1'b0, 8'hF0, 1'b1);
      OP_FAST_ON: begin
        case (idx)
          3'd0:    r = mkStep(SEL_UNL_A, 1'b0, 8'hAA, 1'b0);
          3'd1:    r = mkStep(SEL_UNL_B, 1'b0, 8'h55, 1'b0);
          default: r = mkStep(SEL_UNL_A, 1'b0, 8'h20, 1'b1);
        endcase
      end
      OP_FAST_OFF: begin
        if (idx == 3'd0) r = mkStep(SEL_ZERO, 1'b0, 8'h90, 1'b0);
        else             r = mkStep(SEL_ZERO, 1'b0, 8'h00, 1'b1);
      end
      default: r = mkStep(SEL_ZERO, 1'b0, 8'h00, 1'b1);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/nor_seq_dp.sv
module nor_seq_dp
  import nor_seq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrb_t          strb,
  input  logic [2:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [1:0]        reqDevType,
  input  logic              reqNarrow,
  output logic              reqOk,
  output logic              stepLast,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busData
);

  logic [2:0]        opQ;
  logic [ADDR_W-1:0] addrQ, unlAQ, unlBQ;
  logic [DATA_W-1:0] dataQ;
  logic              fastQ;
  logic [ADDR_W-1:0] unlA, unlB;
  stepInfo_t         cur;

  assign reqOk = (reqDevType != 2'd3) && (reqOp <= 3'd5);

  always_comb begin
    case (reqDevType)
      2'd0:    begin unlA = ADDR_W'('h555);  unlB = ADDR_W'('h2AA); end
      2'd1:    begin unlA = ADDR_W'('hAAA);  unlB = reqNarrow ? ADDR_W'('h555) : ADDR_W'('h554); end
      default: begin unlA = ADDR_W'('h1555); unlB = ADDR_W'('hAAA); end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opQ   <= '0;
      addrQ <= '0;
      dataQ <= '0;
      unlAQ <= '0;
      unlBQ <= '0;
      fastQ <= 1'b0;
    end else begin
      if (strb.load) begin
        opQ   <= reqOp;
        addrQ <= reqAddr;
        dataQ <= reqData;
        unlAQ <= unlA;
        unlBQ <= unlB;
      end
      if (strb.finish) begin
        if (opQ == OP_FAST_ON)  fastQ <= 1'b1;
        if (opQ == OP_FAST_OFF) fastQ <= 1'b0;
      end
    end
  end

  assign cur      = stepLookup(opQ, fastQ, strb.step);
  assign stepLast = cur.last;

  always_comb begin
    case (cur.addrSel)
      SEL_UNL_A:  busAddr = unlAQ;
      SEL_UNL_B:  busAddr = unlBQ;
      SEL_TARGET: busAddr = addrQ;
      default:    busAddr = '0;
    endcase
  end

  assign busData = cur.useData ? dataQ : {{(DATA_W-8){1'b0}}, cur.cmd};

endmodule

// File: rtl/nor_seq_ctrl.sv
module nor_seq_ctrl
  import nor_seq_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [CNT_W-1:0] holdClks,
  input  logic             reqOk,
  input  logic             stepLast,
  output ctlStrb_t         strb,
  output logic             busy,
  output logic             done,
  output logic             error,
  output logic             busWe,
  output logic             busDrive
);

  typedef enum logic [2:0] {ST_IDLE, ST_SETUP, ST_STROBE, ST_HOLD, ST_FIN, ST_ERR} state_e;

  state_e            stateQ;
  logic [CNT_W-1:0]  cntQ, holdQ;
  logic [STEP_W-1:0] stepQ;
  logic              winEnd;

  assign winEnd = (cntQ == holdQ - 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
      holdQ  <= '0;
      stepQ  <= '0;
    end else begin
      case (stateQ)
        ST_IDLE: if (reqValid) begin
          if (reqOk) begin
            holdQ  <= holdClks;
            cntQ   <= '0;
            stepQ  <= '0;
            stateQ <= (holdClks == '0) ? ST_STROBE : ST_SETUP;
          end else begin
            stateQ <= ST_ERR;
          end
        end
        ST_SETUP: begin
          if (winEnd) begin
            cntQ   <= '0;
            stateQ <= ST_STROBE;
          end else cntQ <= cntQ + 1'b1;
        end
        ST_STROBE: begin
          if (holdQ != '0) stateQ <= ST_HOLD;
          else if (stepLast) stateQ <= ST_FIN;
          else stepQ <= stepQ + 1'b1;
        end
        ST_HOLD: begin
          if (winEnd) begin
            cntQ <= '0;
            if (stepLast) stateQ <= ST_FIN;
            else begin
              stepQ  <= stepQ + 1'b1;
              stateQ <= ST_SETUP;
            end
          end else cntQ <= cntQ + 1'b1;
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.load   = (stateQ == ST_IDLE) && reqValid && reqOk;
    strb.finish = (stateQ == ST_FIN);
    strb.step   = stepQ;
  end

  assign busy     = (stateQ != ST_IDLE);
  assign done     = (stateQ == ST_FIN);
  assign error    = (stateQ == ST_ERR);
  assign busWe    = (stateQ == ST_STROBE);
  assign busDrive = (stateQ == ST_SETUP) || (stateQ == ST_STROBE) || (stateQ == ST_HOLD);

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [1:0]        reqDevType,
  input  logic              reqNarrow,
  input  logic [CNT_W-1:0]  holdClks,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              busDrive,
  output logic              busWe,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busData
);

  ctlStrb_t strb;
  logic     reqOk, stepLast;

  nor_seq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .holdClks(holdClks),
    .reqOk(reqOk), .stepLast(stepLast), .strb(strb),
    .busy(busy), .done(done), .error(error), .busWe(busWe), .busDrive(busDrive)
  );

  nor_seq_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqData(reqData), .reqDevType(reqDevType), .reqNarrow(reqNarrow),
    .reqOk(reqOk), .stepLast(stepLast), .busAddr(busAddr), .busData(busData)
  );

endmodule

// File: rtl/nor_seq_chk.sv
module nor_seq_chk #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic              error,
  input logic              busDrive,
  input logic              busWe,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busData
);

  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busDrive && !busWe && $past(busWe)) |-> ($stable(busAddr) && $stable(busData)));

  assert_drive_in_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    busDrive |-> busy);

  assert_done_ends_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  assert_pulses_exclusive_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({done, error, busWe}));

  assert_error_no_bus_R11: assert property (@(posedge clk) disable iff (!rstN)
    error |-> !busDrive);

  assert_error_ends_R11: assert property (@(posedge clk) disable iff (!rstN)
    error |=> !busy);

endmodule

bind nor_cmd_seq nor_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .error(error),
  .busDrive(busDrive), .busWe(busWe), .busAddr(busAddr), .busData(busData)
);

// File: tb/tb_nor_cmd_seq.sv
module tb_nor_cmd_seq;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [2:0] reqOp = '0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqData = '0;
  logic [1:0] reqDevType = '0;
  logic reqNarrow = 1'b0;
  logic [CNT_W-1:0] holdClks = '0;
  logic busy, done, error, busDrive, busWe;
  logic [ADDR_W-1:0] busAddr;
  logic [DATA_W-1:0] busData;

  always #4 clk = ~clk;

  nor_cmd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) dut (.*);

  typedef struct {
    bit drive; bit we; bit bsy; bit dn; bit er;
    logic [ADDR_W-1:0] a; logic [DATA_W-1:0] d;
    string tag;
  } cyc_t;

  cyc_t expQ[$];
  int checks = 0;
  int errors = 0;
  bit checkEn = 0;
  bit fastMode = 0;

  // per-cycle comparison against the reference queue
  always @(negedge clk) begin
    if (checkEn) begin
      cyc_t e;
      if (expQ.size() > 0) e = expQ.pop_front();
      else begin
        e.drive = 0; e.we = 0; e.bsy = 0; e.dn = 0; e.er = 0; e.a = '0; e.d = '0; e.tag = "R10";
      end
      checks++;
      if (busDrive !== e.drive || busWe !== e.we || busy !== e.bsy || done !== e.dn ||
          error !== e.er || (e.drive && (busAddr !== e.a || busData !== e.d))) begin
        errors++;
        $display("FAIL %s: act drv=%0b we=%0b busy=%0b done=%0b err=%0b a=%h d=%h exp drv=%0b we=%0b busy=%0b done=%0b err=%0b a=%h d=%h",
                 e.tag, busDrive, busWe, busy, done, error, busAddr, busData,
                 e.drive, e.we, e.bsy, e.dn, e.er, e.a, e.d);
      end
    end
  end

  function automatic void pushCyc(bit dr, bit w, bit dn, bit er, logic [ADDR_W-1:0] a,
                                  logic [DATA_W-1:0] d, string tag);
    cyc_t c;
    c.drive = dr; c.we = w; c.bsy = 1; c.dn = dn; c.er = er; c.a = a; c.d = d; c.tag = tag;
    expQ.push_back(c);
  endfunction

  function automatic void pushWrite(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d, int n, string tag);
    for (int i = 0; i < n; i++) pushCyc(1, 0, 0, 0, a, d, tag);
    pushCyc(1, 1, 0, 0, a, d, tag);
    for (int i = 0; i < n; i++) pushCyc(1, 0, 0, 0, a, d, tag);
  endfunction

  function automatic logic [DATA_W-1:0] cb(logic [7:0] b);
    return {{(DATA_W-8){1'b0}}, b};
  endfunction

  // reference sequence builder, from the requirements
  function automatic void model(int op, int dev, bit nar, logic [ADDR_W-1:0] ta,
                                logic [DATA_W-1:0] td, int n, string tag);
    logic [ADDR_W-1:0] ua, ub;
    if (dev == 3 || op > 5) begin
      pushCyc(0, 0, 0, 1, '0, '0, tag);
      return;
    end
    if (dev == 0) begin ua = 'h555; ub = 'h2AA; end
    else if (dev == 1) begin ua = 'hAAA; ub = nar ? 'h555 : 'h554; end
    else begin ua = 'h1555; ub = 'hAAA; end
    case (op)
      0: if (fastMode) begin
           pushWrite('0, cb(8'hA0), n, tag); pushWrite(ta, td, n, tag);
         end else begin
           pushWrite(ua, cb(8'hAA), n, tag); pushWrite(ub, cb(8'h55), n, tag);
           pushWrite(ua, cb(8'hA0), n, tag); pushWrite(ta, td, n, tag);
         end
      1, 2: begin
           pushWrite(ua, cb(8'hAA), n, tag); pushWrite(ub, cb(8'h55), n, tag);
           pushWrite(ua, cb(8'h80), n, tag); pushWrite(ua, cb(8'hAA), n, tag);
           pushWrite(ub, cb(8'h55), n, tag);
           if (op == 1) pushWrite(ta, cb(8'h30), n, tag);
           else         pushWrite(ua, cb(8'h10), n, tag);
         end
      3: pushWrite('0, cb(8'hF0), n, tag);
      4: begin
           pushWrite(ua, cb(8'hAA), n, tag); pushWrite(ub, cb(8'h55), n, tag);
           pushWrite(ua, cb(8'h20), n, tag); fastMode = 1;
         end
      default: begin
           pushWrite('0, cb(8'h90), n, tag); pushWrite('0, cb(8'h00), n, tag); fastMode = 0;
         end
    endcase
    pushCyc(0, 0, 1, 0, '0, '0, tag);
  endfunction

  task automatic doReq(int op, int dev, bit nar, logic [ADDR_W-1:0] ta,
                       logic [DATA_W-1:0] td, int n, string tag, bit poke = 0);
    @(negedge clk); #1;
    model(op, dev, nar, ta, td, n, tag);
    reqValid = 1; reqOp = 3'(op); reqDevType = 2'(dev); reqNarrow = nar;
    reqAddr = ta; reqData = td; holdClks = CNT_W'(n);
    @(negedge clk); #1;
    if (poke) begin
      // R10: a second request while busy must be ignored
      reqOp = 3'd3; reqDevType = 2'd0;
      @(negedge clk); #1;
      @(negedge clk); #1;
    end
    reqValid = 0;
    while (expQ.size() > 0) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R10: watchdog expired act=hung exp=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) begin
      @(negedge clk);
      checks++;
      if (busy !== 0 || done !== 0 || error !== 0 || busDrive !== 0 || busWe !== 0) begin
        errors++;
        $display("FAIL R12: act busy=%0b done=%0b err=%0b drv=%0b we=%0b exp all 0",
                 busy, done, error, busDrive, busWe);
      end
    end
    rstN = 1;
    checkEn = 1;
    doReq(0, 0, 0, 24'h012340, 32'hDEADBEEF, 2, "R1");
    doReq(0, 1, 1, 24'h000100, 32'h0000A5A5, 0, "R7");
    doReq(0, 1, 0, 24'h000200, 32'h00005A5A, 1, "R7");
    doReq(1, 2, 0, 24'h040000, 32'h0, 1, "R4");
    doReq(2, 0, 0, 24'h0, 32'h0, 3, "R5");
    doReq(2, 2, 0, 24'h0, 32'h0, 0, "R6");
    doReq(3, 1, 0, 24'h0, 32'h0, 1, "R8");
    doReq(4, 1, 1, 24'h0, 32'h0, 1, "R3");
    doReq(0, 1, 1, 24'h000300, 32'h11223344, 1, "R2");
    doReq(0, 1, 1, 24'h000304, 32'h55667788, 0, "R2");
    doReq(3, 1, 1, 24'h0, 32'h0, 0, "R8");
    doReq(1, 1, 1, 24'h020000, 32'h0, 0, "R4");
    doReq(0, 3, 0, 24'h000400, 32'h1, 1, "R11");
    doReq(6, 0, 0, 24'h000400, 32'h1, 1, "R11");
    doReq(0, 1, 1, 24'h000308, 32'h99AABBCC, 2, "R11");
    doReq(5, 1, 1, 24'h0, 32'h0, 1, "R3");
    doReq(0, 2, 0, 24'h000500, 32'hCAFEF00D, 1, "R9", 1);
    doReq(7, 1, 0, 24'h0, 32'h0, 0, "R11");
    doReq(1, 0, 0, 24'h001000, 32'h0, 4, "R10", 1);
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule